// File: doc/BRIEF.md
# Read-Modify-Write Unary ALU

This block is the single-operand datapath used by read-modify-write instructions. Each cycle it receives a 4-bit opcode, a byte/word select, the operand fetched from memory, the accumulator and the stack pointer. It returns, combinationally, the value to write back to memory and a per-flag write-enable mask. The same cycle's flag values are captured in a small flag register that the block owns. The carry held in that register is the carry input for the rotate and carry-arithmetic operations.

The operations are:

- stores of the accumulator or the stack pointer
- five shifts and rotates
- one's complement
- negate and carry-negate
- decrement and increment
- subtract carry and add carry
- clear

Every operation has a byte form, which works on the low byte only. Stores and the spare opcode never touch the flags. The sequencer drives a store opcode, or the spare opcode, in any cycle where no flag update is wanted.

Top module: `rmw_unary_alu`

## Requirements
- R1: While `rst_n` is low and after it is released, `flags_o` reads 0 until an operation writes a flag. Flag vectors use bit 3 = C, bit 2 = V, bit 1 = N, bit 0 = Z.
- R2: Opcode 0 returns the accumulator and opcode 1 returns the stack pointer. In byte mode only the low byte is returned, zero-extended. `flag_we_o` is 0 and `flags_o` keeps its value.
- R3: Opcode 2 (shift left) and opcode 3 (rotate left through C) move the old MSB into C. Shift left inserts 0 and rotate left inserts the old C. V is set when the MSB changes.
- R4: Opcodes 4, 5 and 6 all move bit 0 into C and clear V. Opcode 4 (logical shift right) inserts 0. Opcode 5 (rotate right through C) inserts the old C. Opcode 6 (arithmetic shift right) keeps the sign bit.
- R5: Opcode 7 returns the one's complement and writes only N and Z (`flag_we_o` = 4'b0011).
- R6: Opcode 8 returns 0 - x, and opcode 9 returns 0 - x - C. C is set on a borrow and V on signed overflow.
- R7: Opcode 10 returns x - 1, and opcode 11 returns x - C. C is set on a borrow and V on signed overflow.
- R8: Opcode 12 returns x + 1, and opcode 13 returns x + C. C is set on a carry out and V on signed overflow.
- R9: Opcode 14 returns 0 and writes C=0, V=0, N=0, Z=1.
- R10: In byte mode the operation uses bits 7:0. The upper result byte is 0, and C, V, N and Z come from the 8-bit result.
- R11: Opcode 15 returns the whole 16-bit operand unchanged and writes no flag, in both modes.
- R12: In every operation except opcodes 0, 1, 7 and 15, `flag_we_o` is 4'b1111. N is the result MSB and Z shows a zero result. At the next rising edge `flags_o` takes the new value of each enabled bit and keeps the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the flag register |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects byte mode |
| operand_i | input | 16 | Operand read from memory |
| acc_i | input | 16 | Accumulator |
| sp_i | input | 16 | Stack pointer |
| result_o | output | 16 | Value to write back |
| flag_we_o | output | 4 | Per-flag write enable {C,V,N,Z} |
| flags_o | output | 4 | Registered flags {C,V,N,Z} |

## Verification
Two things happen at the same clock edge: the flag register captures a new carry, and the next operation reads that carry for a rotate or carry-arithmetic result. The bench provokes this with back-to-back operations, for example a left shift that sets C followed at once by a rotate or an add carry, and with long random streams that draw from all sixteen opcodes in both modes. Each result is judged against a reference model in the bench. That model tracks its own copy of the flags and feeds its own carry into the following operation, so a stale or early carry shows up as a wrong result or wrong flags.

// File: rtl/rmw_pkg.sv
`timescale 1ns/1ps
package rmw_pkg;

   typedef enum logic [3:0] {
      OP_STA  = 4'd0,
      OP_STS  = 4'd1,
      OP_LSL  = 4'd2,
      OP_ROL  = 4'd3,
      OP_LSR  = 4'd4,
      OP_ROR  = 4'd5,
      OP_ASR  = 4'd6,
      OP_COM  = 4'd7,
      OP_NEG  = 4'd8,
      OP_CNG  = 4'd9,
      OP_DEC  = 4'd10,
      OP_CSB  = 4'd11,
      OP_INC  = 4'd12,
      OP_CAD  = 4'd13,
      OP_CLR  = 4'd14,
      OP_NONE = 4'd15
   } rmw_op_e;

   // bit 3 = carry, bit 2 = overflow, bit 1 = negative, bit 0 = zero
   typedef struct packed {
      logic c;
      logic v;
      logic n;
      logic z;
   } flags_t;

   localparam int FLAG_COUNT = 4;

endpackage

// File: rtl/rmw_shift.sv
`timescale 1ns/1ps
module rmw_shift
   import rmw_pkg::*;
#(
   parameter int W = 16
) (
   input  rmw_op_e        op,
   input  logic [W-1:0]   x,
   input  logic           cin,
   output logic [W-1:0]   r,
   output logic           co,
   output logic           vo
);
   localparam int MSB = W - 1;

   always_comb begin
      r  = x;
      co = 1'b0;
      vo = 1'b0;
      case (op)
         OP_LSL: begin
            r  = {x[MSB-1:0], 1'b0};
            co = x[MSB];
            vo = x[MSB] ^ x[MSB-1];
         end
         OP_ROL: begin
            r  = {x[MSB-1:0], cin};
            co = x[MSB];
            vo = x[MSB] ^ x[MSB-1];
         end
         OP_LSR: begin
            r  = {1'b0, x[MSB:1]};
            co = x[0];
         end
         OP_ROR: begin
            r  = {cin, x[MSB:1]};
            co = x[0];
         end
         OP_ASR: begin
            r  = {x[MSB], x[MSB:1]};
            co = x[0];
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/rmw_addsub.sv
`timescale 1ns/1ps
module rmw_addsub #(
   parameter int W = 16
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] r,
   output logic         co,
   output logic         vo
);
   localparam int MSB = W - 1;

   logic [W:0] wide;

   always_comb begin
      if (sub) wide = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      else     wide = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      r  = wide[W-1:0];
      co = wide[W];   // carry out on add, borrow on subtract
      if (sub) vo = (a[MSB] ^ b[MSB]) & (a[MSB] ^ r[MSB]);
      else     vo = ~(a[MSB] ^ b[MSB]) & (a[MSB] ^ r[MSB]);
   end
endmodule

// File: rtl/rmw_lane.sv
`timescale 1ns/1ps
module rmw_lane
   import rmw_pkg::*;
#(
   parameter int W = 16
) (
   input  rmw_op_e        op,
   input  logic [W-1:0]   x,
   input  logic           cin,
   output logic [W-1:0]   r,
   output flags_t         f,
   output logic [3:0]     we
);
   localparam int MSB = W - 1;

   logic [W-1:0] sh_r, as_r, as_a, as_b;
   logic         sh_c, sh_v, as_c, as_v, as_cin, as_sub;

   rmw_shift #(.W(W)) u_shift (
      .op (op), .x (x), .cin (cin),
      .r  (sh_r), .co (sh_c), .vo (sh_v)
   );

   // operand steering for the shared adder/subtractor
   always_comb begin
      as_a   = x;
      as_b   = '0;
      as_cin = 1'b0;
      as_sub = 1'b0;
      case (op)
         OP_NEG: begin as_a = '0; as_b = x; as_sub = 1'b1; end
         OP_CNG: begin as_a = '0; as_b = x; as_cin = cin; as_sub = 1'b1; end
         OP_DEC: begin as_b = {{(W-1){1'b0}}, 1'b1}; as_sub = 1'b1; end
         OP_CSB: begin as_cin = cin; as_sub = 1'b1; end
         OP_INC: begin as_b = {{(W-1){1'b0}}, 1'b1}; end
         OP_CAD: begin as_cin = cin; end
         default: ;
      endcase
   end

   rmw_addsub #(.W(W)) u_addsub (
      .a (as_a), .b (as_b), .cin (as_cin), .sub (as_sub),
      .r (as_r), .co (as_c), .vo (as_v)
   );

   always_comb begin
      r   = x;
      f   = '0;
      we  = 4'b1111;
      case (op)
         OP_STA, OP_STS, OP_NONE: we = 4'b0000;
         OP_LSL, OP_ROL, OP_LSR, OP_ROR, OP_ASR: begin
            r   = sh_r;
            f.c = sh_c;
            f.v = sh_v;
         end
         OP_COM: begin
            r  = ~x;
            we = 4'b0011;
         end
         OP_NEG, OP_CNG, OP_DEC, OP_CSB, OP_INC, OP_CAD: begin
            r   = as_r;
            f.c = as_c;
            f.v = as_v;
         end
         OP_CLR: r = '0;
         default: we = 4'b0000;
      endcase
      f.n = r[MSB];
      f.z = (r == '0);
   end
endmodule

// File: rtl/rmw_flag_reg.sv
`timescale 1ns/1ps
module rmw_flag_reg
   import rmw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] we,
   input  flags_t     d,
   output flags_t     q
);
   logic [FLAG_COUNT-1:0] dv, qv;

   assign dv = d;
   assign q  = qv;

   for (genvar i = 0; i < FLAG_COUNT; i++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     bit_q <= 1'b0;
         else if (we[i]) bit_q <= dv[i];
      end
      assign qv[i] = bit_q;
   end
endmodule

// File: rtl/rmw_unary_alu.sv
`timescale 1ns/1ps
module rmw_unary_alu
   import rmw_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int BYTE_W   = 8,
   parameter bit BYTE_OPS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_i,
   input  logic              byte_i,
   input  logic [DATA_W-1:0] operand_i,
   input  logic [DATA_W-1:0] acc_i,
   input  logic [DATA_W-1:0] sp_i,
   output logic [DATA_W-1:0] result_o,
   output logic [3:0]        flag_we_o,
   output logic [3:0]        flags_o
);
   localparam int HI_W = DATA_W - BYTE_W;

   if (BYTE_W < 2 || BYTE_W >= DATA_W) begin : g_bad_width
      $error("rmw_unary_alu: BYTE_W must lie in [2, DATA_W)");
   end

   rmw_op_e op;
   flags_t  flags_q, w_f, b_f, sel_f;
   logic [DATA_W-1:0] w_r, src;
   logic [BYTE_W-1:0] b_r;
   logic [3:0]        w_we, b_we, sel_we;
   logic              byte_sel;

   assign op = rmw_op_e'(op_i);

   rmw_lane #(.W(DATA_W)) u_word (
      .op (op), .x (operand_i), .cin (flags_q.c),
      .r  (w_r), .f (w_f), .we (w_we)
   );

   if (BYTE_OPS) begin : g_byte
      rmw_lane #(.W(BYTE_W)) u_byte (
         .op (op), .x (operand_i[BYTE_W-1:0]), .cin (flags_q.c),
         .r  (b_r), .f (b_f), .we (b_we)
      );
      assign byte_sel = byte_i;
   end else begin : g_no_byte
      assign b_r      = w_r[BYTE_W-1:0];
      assign b_f      = w_f;
      assign b_we     = w_we;
      assign byte_sel = 1'b0;
   end

   assign src = (op == OP_STS) ? sp_i : acc_i;

   always_comb begin
      sel_f  = byte_sel ? b_f  : w_f;
      sel_we = byte_sel ? b_we : w_we;
      case (op)
         OP_STA, OP_STS: begin
            result_o = byte_sel ? {{HI_W{1'b0}}, src[BYTE_W-1:0]} : src;
            sel_we   = 4'b0000;
         end
         OP_NONE: begin
            result_o = operand_i;
            sel_we   = 4'b0000;
         end
         default: result_o = byte_sel ? {{HI_W{1'b0}}, b_r} : w_r;
      endcase
   end

   rmw_flag_reg u_flags (
      .clk (clk), .rst_n (rst_n), .we (sel_we), .d (sel_f), .q (flags_q)
   );

   assign flag_we_o = sel_we;
   assign flags_o   = flags_q;
endmodule

// File: rtl/rmw_unary_alu_chk.sv
`timescale 1ns/1ps
module rmw_unary_alu_chk #(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        op_i,
   input logic              byte_i,
   input logic [DATA_W-1:0] operand_i,
   input logic [DATA_W-1:0] result_o,
   input logic [3:0]        flag_we_o,
   input logic [3:0]        flags_o
);
   logic res_zero;
   assign res_zero = byte_i ? (result_o[BYTE_W-1:0] == '0) : (result_o == '0);

   assert_store_no_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd0 || op_i == 4'd1) |-> flag_we_o == 4'b0000);

   assert_com_nz_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 4'd7 |-> flag_we_o == 4'b0011);

   assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 4'd14 |-> result_o == '0);

   assert_byte_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_i && op_i != 4'd15) |-> result_o[DATA_W-1:BYTE_W] == '0);

   assert_spare_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 4'd15 |-> (result_o == operand_i && flag_we_o == 4'b0000));

   assert_flags_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we_o == 4'b0000 |=> flags_o == $past(flags_o));

   assert_zero_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we_o[0] |=> flags_o[0] == $past(res_zero));
endmodule

bind rmw_unary_alu rmw_unary_alu_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
   .clk (clk), .rst_n (rst_n), .op_i (op_i), .byte_i (byte_i),
   .operand_i (operand_i), .result_o (result_o),
   .flag_we_o (flag_we_o), .flags_o (flags_o)
);

// File: tb/rmw_unary_alu_test.sv
`timescale 1ns/1ps
module rmw_unary_alu_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op_i = 4'd0;
   logic        byte_i = 1'b0;
   logic [15:0] operand_i = '0, acc_i = '0, sp_i = '0;
   logic [15:0] result_o;
   logic [3:0]  flag_we_o, flags_o;

   int total = 0;
   int bad = 0;
   logic [3:0] exp_flags = 4'd0;

   always #2 clk = ~clk;

   rmw_unary_alu uut (
      .clk (clk), .rst_n (rst_n), .op_i (op_i), .byte_i (byte_i),
      .operand_i (operand_i), .acc_i (acc_i), .sp_i (sp_i),
      .result_o (result_o), .flag_we_o (flag_we_o), .flags_o (flags_o)
   );

   function automatic string tag(input logic [3:0] op, input logic b);
      string t;
      case (op)
         4'd0, 4'd1:   t = "R2";
         4'd2, 4'd3:   t = "R3";
         4'd4, 4'd5, 4'd6: t = "R4";
         4'd7:         t = "R5";
         4'd8, 4'd9:   t = "R6";
         4'd10, 4'd11: t = "R7";
         4'd12, 4'd13: t = "R8";
         4'd14:        t = "R9";
         default:      t = "R11";
      endcase
      if (b && op != 4'd15) t = {t, "/R10"};
      return t;
   endfunction

   // reference model, flags as {C,V,N,Z}
   function automatic void ref_model(input logic [3:0] op, input logic b,
         input logic [15:0] x, acc, sp, input logic c,
         output logic [15:0] r, output logic [3:0] we, output logic [3:0] nf);
      logic [15:0] m, xs, mn, mx, cw;
      int msb;
      logic fc, fv;
      m = b ? 16'h00FF : 16'hFFFF;
      msb = b ? 7 : 15;
      xs = x & m;
      mn = b ? 16'h0080 : 16'h8000;
      mx = m >> 1;
      cw = {15'd0, c};
      fc = 1'b0; fv = 1'b0; we = 4'hF; r = '0;
      case (op)
         4'd0: begin r = acc & m; we = 4'h0; end
         4'd1: begin r = sp & m;  we = 4'h0; end
         4'd2: begin r = (xs << 1) & m; fc = xs[msb]; fv = r[msb] ^ xs[msb]; end
         4'd3: begin r = ((xs << 1) | cw) & m; fc = xs[msb]; fv = r[msb] ^ xs[msb]; end
         4'd4: begin r = xs >> 1; fc = xs[0]; end
         4'd5: begin r = (xs >> 1) | (cw << msb); fc = xs[0]; end
         4'd6: begin r = (xs >> 1) | (xs & mn); fc = xs[0]; end
         4'd7: begin r = ~xs & m; we = 4'b0011; end
         4'd8: begin r = (16'd0 - xs) & m; fc = (xs != 0); fv = (xs == mn); end
         4'd9: begin r = (16'd0 - xs - cw) & m; fc = (xs != 0) || c; fv = (xs == mn) && !c; end
         4'd10: begin r = (xs - 16'd1) & m; fc = (xs == 0); fv = (xs == mn); end
         4'd11: begin r = (xs - cw) & m; fc = (xs == 0) && c; fv = (xs == mn) && c; end
         4'd12: begin r = (xs + 16'd1) & m; fc = (xs == m); fv = (xs == mx); end
         4'd13: begin r = (xs + cw) & m; fc = (xs == m) && c; fv = (xs == mx) && c; end
         4'd14: r = '0;
         default: begin r = x; we = 4'h0; end
      endcase
      nf = {fc, fv, r[msb], (r == 16'd0)};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic b,
                        input logic [15:0] x, input logic [15:0] acc, input logic [15:0] sp);
      logic [15:0] er;
      logic [3:0]  ewe, ef;
      string t;
      @(negedge clk);
      op_i = op; byte_i = b; operand_i = x; acc_i = acc; sp_i = sp;
      #1;
      ref_model(op, b, x, acc, sp, exp_flags[3], er, ewe, ef);
      t = tag(op, b);
      check(t, "result", result_o, er);
      check({t, "/R12"}, "flag_we", {12'd0, flag_we_o}, {12'd0, ewe});
      @(posedge clk);
      #1;
      exp_flags = (exp_flags & ~ewe) | (ef & ewe);
      check({t, "/R12"}, "flags", {12'd0, flags_o}, {12'd0, exp_flags});
   endtask

   initial begin
      #(4 * 100000);
      total++; bad++;
      $display("FAIL watchdog R12 actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      check("R1", "flags in reset", {12'd0, flags_o}, 16'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1", "flags after reset", {12'd0, flags_o}, 16'd0);

      // directed corners
      apply(4'd2,  1'b0, 16'h8000, 16'h0, 16'h0);   // lsl: C=1 V=1 Z=1
      apply(4'd3,  1'b0, 16'h0000, 16'h0, 16'h0);   // rol picks up carry
      apply(4'd0,  1'b1, 16'hFFFF, 16'h1234, 16'h0); // byte store, flags held
      apply(4'd1,  1'b0, 16'h0000, 16'h0, 16'hBEEF);
      apply(4'd5,  1'b1, 16'h0001, 16'h0, 16'h0);   // ror byte
      apply(4'd5,  1'b1, 16'h0000, 16'h0, 16'h0);   // ror inserts carry
      apply(4'd6,  1'b0, 16'h8001, 16'h0, 16'h0);
      apply(4'd4,  1'b0, 16'h8001, 16'h0, 16'h0);
      apply(4'd7,  1'b0, 16'h00FF, 16'h0, 16'h0);
      apply(4'd8,  1'b0, 16'h8000, 16'h0, 16'h0);
      apply(4'd8,  1'b0, 16'h0000, 16'h0, 16'h0);
      apply(4'd2,  1'b0, 16'h8000, 16'h0, 16'h0);   // set C
      apply(4'd9,  1'b0, 16'h0000, 16'h0, 16'h0);   // 0-0-1
      apply(4'd10, 1'b0, 16'h0000, 16'h0, 16'h0);
      apply(4'd10, 1'b1, 16'h1280, 16'h0, 16'h0);
      apply(4'd12, 1'b0, 16'hFFFF, 16'h0, 16'h0);
      apply(4'd13, 1'b1, 16'h00FF, 16'h0, 16'h0);   // carry chain into byte add
      apply(4'd12, 1'b0, 16'h7FFF, 16'h0, 16'h0);
      apply(4'd11, 1'b1, 16'h0080, 16'h0, 16'h0);
      apply(4'd14, 1'b0, 16'hABCD, 16'h0, 16'h0);
      apply(4'd15, 1'b1, 16'hABCD, 16'h0, 16'h0);
      apply(4'd15, 1'b0, 16'h1357, 16'h0, 16'h0);

      // random stream
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] x;
         logic [3:0]  op;
         x  = 16'($urandom);
         op = 4'($urandom);
         case ($urandom % 8)
            0: x = 16'h0000;
            1: x = 16'hFFFF;
            2: x = 16'h8000;
            3: x = 16'h007F;
            default: ;
         endcase
         apply(op, 1'($urandom), x, 16'($urandom), 16'($urandom));
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule